// File: doc/BRIEF.md
# Atomic Bit-Operation Register Bank

This block is a small bank of control registers behind a simple memory-mapped bus port. Each register can be reached at four address windows. Address bits [13:12] pick the window, and the window decides how a write changes the register. One window replaces the register with the write data. The other three toggle, set or clear only the bits marked by ones in the write data.

The host can therefore flip, raise or drop single control bits in one bus write, without first reading the register. There is no read-modify-write sequence that another agent could interrupt. The full contents of every register are driven out in parallel to the logic that the registers control. Reads return the current register value through any window and change nothing.

The register index comes from word-aligned address bits starting at bit 2. Byte-offset bits and any unused bits below bit 12 are ignored. Each update takes effect at the clock edge that samples the write strobe.

Top module: `alias_regbank`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, every register holds RESET_VAL (zero by default) on `reg_q`.
- R2: A write with address bits [13:12] = 0 replaces the addressed register with `bus_wdata`.
- R3: A write with address bits [13:12] = 1 makes the addressed register equal to its old value XOR `bus_wdata`.
- R4: A write with address bits [13:12] = 2 makes the addressed register equal to its old value OR `bus_wdata`.
- R5: A write with address bits [13:12] = 3 makes the addressed register equal to its old value AND NOT `bus_wdata`.
- R6: The register index is address bits [IDX_W+1:2]. Bits [1:0] and bits [11:IDX_W+2] have no effect on which register is accessed.
- R7: With `bus_we` low, `bus_rdata` equals the addressed register in every window, and no register changes.
- R8: A write changes only the addressed register. All other registers keep their values.
- R9: The new value is visible on `reg_q` and on `bus_rdata` in the cycle right after the write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address. Bits [13:12] select the window, bits [IDX_W+1:2] select the register |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | DATA_W | Write data or bit mask |
| bus_rdata | output | DATA_W | Current value of the addressed register (combinational) |
| reg_q | output | DATA_W*2^IDX_W | All register contents, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench builds the block with its defaults: eight 32-bit registers and a 14-bit address. This leaves seven ignored bits between the index and the window field. Filling those bits, and the byte-offset bits, with random junk puts index aliasing within reach. The register count is small enough that a long random run writes every register through all four windows many times. Back-to-back operations on the same register exercise chains of toggle, set and clear on values that earlier updates left behind.

// File: rtl/alias_regbank.sv
module alias_regbank #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 3,
  parameter int ADDR_W = 14,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_we,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  output logic [(DATA_W<<IDX_W)-1:0]        reg_q
);
  localparam int NREGS = 1 << IDX_W;
  localparam int WIN_LSB = 12;

  typedef enum logic [1:0] {
    WIN_PLAIN = 2'd0,
    WIN_TOGGLE = 2'd1,
    WIN_SET = 2'd2,
    WIN_CLEAR = 2'd3
  } win_e;

  win_e             win;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] regs [NREGS];

  assign win = win_e'(bus_addr[WIN_LSB+1:WIN_LSB]);
  assign idx = bus_addr[IDX_W+1:2];
  assign bus_rdata = regs[idx];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [DATA_W-1:0] nxt;
    logic              hit;

    assign hit = bus_we && (idx == IDX_W'(i));

    always_comb begin
      unique case (win)
        WIN_PLAIN:  nxt = bus_wdata;
        WIN_TOGGLE: nxt = regs[i] ^ bus_wdata;
        WIN_SET:    nxt = regs[i] | bus_wdata;
        WIN_CLEAR:  nxt = regs[i] & ~bus_wdata;
        default:    nxt = regs[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= RESET_VAL;
      else if (hit) regs[i] <= nxt;
    end

    assign reg_q[i*DATA_W +: DATA_W] = regs[i];
  end
endmodule

// File: rtl/alias_regbank_chk.sv
module alias_regbank_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 3,
  parameter int ADDR_W = 14,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [(DATA_W<<IDX_W)-1:0] reg_q
);
  localparam int TOT = DATA_W << IDX_W;

  logic [IDX_W-1:0]  cur_idx, p_idx;
  logic [1:0]        p_win;
  logic              p_we;
  logic [DATA_W-1:0] p_wd, p_old, tgt;
  logic [TOT-1:0]    p_q, others_mask;

  assign cur_idx = bus_addr[IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_we <= 1'b0; p_idx <= '0; p_win <= '0; p_wd <= '0; p_old <= '0; p_q <= '0;
    end else begin
      p_we <= bus_we;
      p_idx <= cur_idx;
      p_win <= bus_addr[13:12];
      p_wd <= bus_wdata;
      p_old <= reg_q[cur_idx*DATA_W +: DATA_W];
      p_q <= reg_q;
    end
  end

  assign tgt = reg_q[p_idx*DATA_W +: DATA_W];
  assign others_mask = ~({{(TOT-DATA_W){1'b0}}, {DATA_W{1'b1}}} << (p_idx*DATA_W));

  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> reg_q == {(1<<IDX_W){RESET_VAL}}); // R1
  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_win == 2'd0) |-> tgt == p_wd); // R2
  AST_TOGGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_win == 2'd1) |-> tgt == (p_old ^ p_wd)); // R3
  AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_win == 2'd2) |-> tgt == (p_old | p_wd)); // R4
  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_win == 2'd3) |-> tgt == (p_old & ~p_wd)); // R5
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(reg_q)); // R7
  AST_READ_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == reg_q[cur_idx*DATA_W +: DATA_W]); // R7
  AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    p_we |-> ((reg_q ^ p_q) & others_mask) == '0); // R8
endmodule

bind alias_regbank alias_regbank_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .RESET_VAL(RESET_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_q(reg_q)
);

// File: tb/alias_regbank_bench.sv
`timescale 1ns/1ps
module alias_regbank_bench;
  localparam int DW = 32;
  localparam int IW = 3;
  localparam int AW = 14;
  localparam int NR = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW*NR-1:0] reg_q;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [NR];

  always #10 clk = ~clk;

  alias_regbank #(.DATA_W(DW), .IDX_W(IW), .ADDR_W(AW)) u_alias_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_q(reg_q));

  function automatic logic [DW-1:0] apply(logic [1:0] w, logic [DW-1:0] o, logic [DW-1:0] d);
    case (w)
      2'd0: return d;
      2'd1: return o ^ d;
      2'd2: return o | d;
      default: return o & ~d;
    endcase
  endfunction

  function automatic logic [AW-1:0] mk(logic [1:0] w, int idx, logic [6:0] junk_hi, logic [1:0] junk_lo);
    return {w, junk_hi, idx[IW-1:0], junk_lo};
  endfunction

  task automatic chk(string req, logic [DW*NR-1:0] got, logic [DW*NR-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [DW*NR-1:0] flat();
    logic [DW*NR-1:0] f;
    for (int i = 0; i < NR; i++) f[i*DW +: DW] = model[i];
    return f;
  endfunction

  task automatic wr(string req, logic [AW-1:0] a, logic [DW-1:0] d);
    int idx;
    idx = int'(a[IW+1:2]);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(posedge clk);
    model[idx] = apply(a[13:12], model[idx], d);
    @(negedge clk);
    bus_we = 0; bus_wdata = $urandom;
    #1;
    chk(req, {{(DW*NR-DW){1'b0}}, bus_rdata}, {{(DW*NR-DW){1'b0}}, model[idx]}); // R9 read next cycle
    chk(req, reg_q, flat());
  endtask

  task automatic rd(string req, logic [AW-1:0] a);
    @(negedge clk);
    bus_addr = a; bus_we = 0; bus_wdata = $urandom;
    #1;
    chk(req, {{(DW*NR-DW){1'b0}}, bus_rdata}, {{(DW*NR-DW){1'b0}}, model[int'(a[IW+1:2])]});
    @(negedge clk);
    chk(req, reg_q, flat());
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NR; i++) model[i] = '0;
    #35;
    chk("R1 during reset", reg_q, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", reg_q, '0);

    wr("R2 plain", mk(2'd0, 2, 7'h00, 2'b00), 32'hA5A5_0F0F);
    wr("R3 toggle", mk(2'd1, 2, 7'h00, 2'b00), 32'hFFFF_0000);
    wr("R4 set", mk(2'd2, 2, 7'h00, 2'b00), 32'h0000_00F0);
    wr("R5 clear", mk(2'd3, 2, 7'h00, 2'b00), 32'h0000_0F0F);
    wr("R5 clear all", mk(2'd3, 2, 7'h00, 2'b00), 32'hFFFF_FFFF);
    wr("R4 set all", mk(2'd2, 7, 7'h00, 2'b00), 32'hFFFF_FFFF);
    wr("R3 toggle zero mask", mk(2'd1, 7, 7'h00, 2'b00), 32'h0);
    wr("R6 junk bits index 5", mk(2'd0, 5, 7'h7F, 2'b11), 32'h1234_5678);
    rd("R6 read index 5 via clean address", mk(2'd0, 5, 7'h00, 2'b00));
    wr("R8 write index 0 leaves others", mk(2'd0, 0, 7'h2A, 2'b01), 32'hDEAD_BEEF);
    for (int w = 0; w < 4; w++)
      rd("R7 read through window", mk(w[1:0], 7, 7'h55, 2'b10));

    for (int n = 0; n < 400; n++) begin
      logic [1:0] w;
      int idx;
      w = 2'($urandom_range(0, 3));
      idx = int'($urandom_range(0, NR - 1));
      if ($urandom_range(0, 3) == 0)
        rd("R7 random read", mk(w, idx, 7'($urandom), 2'($urandom)));
      else
        case (w)
          2'd0: wr("R2 random", mk(w, idx, 7'($urandom), 2'($urandom)), $urandom);
          2'd1: wr("R3 random", mk(w, idx, 7'($urandom), 2'($urandom)), $urandom);
          2'd2: wr("R4 random", mk(w, idx, 7'($urandom), 2'($urandom)), $urandom);
          default: wr("R5 random", mk(w, idx, 7'($urandom), 2'($urandom)), $urandom);
        endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule